// File: doc/BRIEF.md
# UART Power-Saving Controller

This block decides when a serial port may power down and when it has to be awake. It runs a state machine with four states: ST_ACTIVE (port awake), ST_IDLE (port asleep), ST_WAKE (fixed wake latency after a wake request) and ST_PEEK (short awake window inside a sleep cycle). From this state it drives the UART enable, the active-low clear-to-send output, an active-mode indicator and a flag that marks the character which caused a wake as invalid. All durations are counts of a timebase `tick` and are set by parameters.

Three power-saving modes are selected by `mode_sel`. In mode 0 (off) the port never sleeps. In mode 1 (timer) the port sleeps after an inactivity timeout. In mode 2 (RTS) the port also sleeps after the timeout, but only while `rts_on` is low. Code 3 is reserved and acts as mode 0. Mode 2 with `flow_en` high is an illegal combination and also acts as mode 0. The transitions are:
- ACTIVE→IDLE: the inactivity counter has expired and nothing holds the port awake.
- IDLE→WAKE: a receive-line rising edge or RTS ON.
- IDLE→PEEK: the sleep window expires, in timer mode with flow control only.
- PEEK→IDLE: the peek window expires with no character.
- PEEK→ACTIVE: a character arrives.
- WAKE→ACTIVE: the wake latency expires.
- Any state→ACTIVE: a forced wake (USB active, or the effective mode is off).

Top module: `uart_psave_ctrl`

## Requirements
- R1: While reset is held, `active`=1, `uart_en`=1, `cts_n`=0 and `drop_first`=0. The inactivity counter is loaded at reset, so with `tick` held high and no activity, `active` falls on the (TIMEOUT_TICKS+1)th clock edge after reset is released.
- R2: In ST_ACTIVE with nothing holding the port awake, the block enters ST_IDLE on the (TIMEOUT_TICKS+1)th clock edge after the edge that loaded the inactivity counter, with `tick` held high. The counter only advances on clock edges where `tick` is high.
- R3: Each `char_rx` pulse sampled in ST_ACTIVE reloads the inactivity counter. Steady activity therefore keeps the port awake indefinitely.
- R4: `cts_n` is active low: 0 means the port accepts data. `cts_n`=1 exactly when `flow_en`=1 and the state is ST_IDLE or ST_WAKE. Otherwise `cts_n`=0, so it is always 0 when `flow_en`=0.
- R5: In timer mode with `flow_en`=1, ST_IDLE lasts IDLE_WIN_TICKS+1 ticks. The block then enters ST_PEEK (`uart_en`=1, `cts_n`=0, `active`=0) for PEEK_TICKS+1 ticks and returns to ST_IDLE. A `char_rx` pulse during ST_PEEK moves the block to ST_ACTIVE on that edge.
- R6: In RTS mode (`mode_sel`=2, `flow_en`=0), `rts_on`=1 keeps the block in ST_ACTIVE. With `rts_on`=0 the timeout of R2 applies. ST_IDLE then holds `uart_en`=0 and does not cycle through ST_PEEK.
- R7: In RTS mode, `rts_on` rising to 1 in ST_IDLE moves the block to ST_WAKE on the next edge, with `drop_first`=0. ST_ACTIVE (`active`=1, `uart_en`=1) follows WAKE_TICKS+1 ticks later.
- R8: `mode_sel`=2 with `flow_en`=1, and `mode_sel`=3, both act as mode 0: the port never sleeps and `cts_n` stays 0.
- R9: `tx_pend`=1 sets `uart_en`=1 in every state, in the same cycle.
- R10: In ST_IDLE, a rising edge on `rxd` reaches ST_WAKE on the third clock edge after the line changes (two synchronizer stages plus one edge-detect stage). From that edge `drop_first`=1 until ST_ACTIVE is entered WAKE_TICKS+1 ticks later. `char_rx` pulses during ST_WAKE are ignored and do not change that timing.
- R11: `usb_active`=1 moves the block to ST_ACTIVE on the next edge from any state, clears `drop_first`, and keeps the port awake for as long as it stays high.
- R12: In mode 0 the block enters ST_ACTIVE on the next edge and stays there, with `uart_en`=1.
- R13: A rising edge on `rxd` in ST_ACTIVE has no effect: `drop_first` stays 0 and `active` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase pulse; all durations count these |
| mode_sel | input | 2 | 0 off, 1 timer, 2 RTS-gated, 3 reserved (acts as off) |
| flow_en | input | 1 | Hardware flow control enabled |
| rts_on | input | 1 | Host request-to-send, 1 = ON |
| rxd | input | 1 | Raw receive data line (asynchronous) |
| char_rx | input | 1 | One-cycle pulse per received character |
| tx_pend | input | 1 | Transmit data waiting |
| usb_active | input | 1 | USB link active; forces awake |
| uart_en | output | 1 | UART enable |
| cts_n | output | 1 | Clear to send, active low |
| active | output | 1 | Block is in active mode |
| drop_first | output | 1 | Character that caused the wake is invalid |

## Verification
The inactivity timer is swept over every spacing of a restart pulse from 0 to TIMEOUT_TICKS cycles. This shows whether each restart truly reloads the counter, as opposed to extending it by a fixed amount or being ignored near expiry. Receive-line wakes are applied at every legal offset inside the sleep window, with a stray character injected during the wake latency. These runs separate a correct fixed latency from one that restarts or shortens. The peek cycle, RTS hold and wake, tick gating, the illegal and reserved modes, and a USB override in each sleeping state are each driven with a pattern whose exact expected cycle count is computed from the parameters.

// File: rtl/psave_pkg.sv
package psave_pkg;

    typedef enum logic [1:0] {
        PS_OFF   = 2'd0,
        PS_TIMER = 2'd1,
        PS_RTS   = 2'd2,
        PS_RSVD  = 2'd3
    } psave_mode_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_IDLE   = 2'd1,
        ST_WAKE   = 2'd2,
        ST_PEEK   = 2'd3
    } psave_state_e;

endpackage

// File: rtl/psave_cnt.sv
// Loadable down-counter that steps once per timebase tick and stops at zero.
module psave_cnt #(
    parameter int W       = 8,
    parameter int RST_VAL = 0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= W'(RST_VAL);
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);
endmodule

// File: rtl/psave_rise.sv
// Synchronizes an asynchronous line and flags its low-to-high edges.
module psave_rise #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    genvar i;
    generate
        for (i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= din;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[i] <= 1'b0;
                    else        sync_q[i] <= sync_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;
endmodule

// File: rtl/uart_psave_ctrl.sv
module uart_psave_ctrl
    import psave_pkg::*;
#(
    parameter int TIMEOUT_TICKS  = 920,
    parameter int IDLE_WIN_TICKS = 210,
    parameter int PEEK_TICKS     = 2,
    parameter int WAKE_TICKS     = 2,
    parameter int SYNC_STAGES    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic [1:0] mode_sel,
    input  logic       flow_en,
    input  logic       rts_on,
    input  logic       rxd,
    input  logic       char_rx,
    input  logic       tx_pend,
    input  logic       usb_active,
    output logic       uart_en,
    output logic       cts_n,
    output logic       active,
    output logic       drop_first
);
    localparam int MAX_AB = (TIMEOUT_TICKS > IDLE_WIN_TICKS) ? TIMEOUT_TICKS : IDLE_WIN_TICKS;
    localparam int MAX_CD = (PEEK_TICKS > WAKE_TICKS) ? PEEK_TICKS : WAKE_TICKS;
    localparam int MAX_ALL = (MAX_AB > MAX_CD) ? MAX_AB : MAX_CD;
    localparam int CW = $clog2(MAX_ALL + 2);

    psave_state_e state_q, state_d;
    psave_mode_e  mode_raw, mode_eff;

    logic force_on, rts_hold, cycle_en;
    logic rx_rise, idle_zero, win_zero;
    logic idle_load, win_load;
    logic [CW-1:0] win_val;
    logic drop_q;

    // Mode resolution: reserved code and RTS mode with flow control fall back to off
    always_comb begin
        mode_raw = psave_mode_e'(mode_sel);
        mode_eff = mode_raw;
        if (mode_raw == PS_RSVD || (mode_raw == PS_RTS && flow_en)) begin
            mode_eff = PS_OFF;
        end
    end

    assign force_on = usb_active | (mode_eff == PS_OFF);
    assign rts_hold = (mode_eff == PS_RTS) & rts_on;
    assign cycle_en = (mode_eff == PS_TIMER) & flow_en;

    psave_rise #(.STAGES(SYNC_STAGES)) u_rx_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (rxd),
        .rise  (rx_rise)
    );

    // Inactivity timer: held loaded outside active mode and while kept awake
    assign idle_load = (state_q != ST_ACTIVE) | char_rx | force_on | rts_hold;

    psave_cnt #(.W(CW), .RST_VAL(TIMEOUT_TICKS)) u_idle_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (idle_load),
        .load_val (CW'(TIMEOUT_TICKS)),
        .zero     (idle_zero)
    );

    // Window timer shared by sleep window, peek window and wake latency
    always_comb begin
        unique case (state_d)
            ST_IDLE:   win_val = CW'(IDLE_WIN_TICKS);
            ST_PEEK:   win_val = CW'(PEEK_TICKS);
            ST_WAKE:   win_val = CW'(WAKE_TICKS);
            ST_ACTIVE: win_val = '0;
        endcase
    end

    assign win_load = (state_d != state_q);

    psave_cnt #(.W(CW), .RST_VAL(0)) u_win_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .load     (win_load),
        .load_val (win_val),
        .zero     (win_zero)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_ACTIVE: begin
                if (!force_on && !rts_hold && !char_rx && idle_zero) state_d = ST_IDLE;
            end
            ST_IDLE: begin
                if (force_on)                    state_d = ST_ACTIVE;
                else if (rx_rise || rts_hold)    state_d = ST_WAKE;
                else if (cycle_en && win_zero)   state_d = ST_PEEK;
            end
            ST_WAKE: begin
                if (force_on || win_zero)        state_d = ST_ACTIVE;
            end
            ST_PEEK: begin
                if (force_on || char_rx)         state_d = ST_ACTIVE;
                else if (win_zero)               state_d = ST_IDLE;
            end
        endcase
    end

    // State register and wake-character flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_ACTIVE;
            drop_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_d == ST_WAKE)
                drop_q <= drop_q | ((state_q == ST_IDLE) & rx_rise);
            else
                drop_q <= 1'b0;
        end
    end

    // Outputs
    always_comb begin
        uart_en    = tx_pend;
        cts_n      = 1'b0;
        active     = 1'b0;
        drop_first = drop_q;
        unique case (state_q)
            ST_ACTIVE: begin
                uart_en = 1'b1;
                active  = 1'b1;
            end
            ST_PEEK: begin
                uart_en = 1'b1;
            end
            ST_IDLE, ST_WAKE: begin
                cts_n = flow_en;
            end
        endcase
    end
endmodule

// File: rtl/psave_ctrl_chk.sv
module psave_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [1:0] mode_sel,
    input logic       flow_en,
    input logic       rts_on,
    input logic       tx_pend,
    input logic       usb_active,
    input logic       uart_en,
    input logic       cts_n,
    input logic       active,
    input logic       drop_first
);
    AST_CTS_LOW_NO_FLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !flow_en |-> !cts_n); // R4
    AST_CTS_HIGH_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (flow_en && !uart_en) |-> cts_n); // R4
    AST_RTS_ON_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && !flow_en && rts_on && active) |=> active); // R6
    AST_ILLEGAL_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd2 && flow_en) |=> active); // R8
    AST_TX_FORCES_UART: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pend |-> uart_en); // R9
    AST_DROP_ONLY_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        drop_first |-> !active); // R10
    AST_USB_KEEPS_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        usb_active |=> (active && !drop_first)); // R11
    AST_OFF_MODE_AWAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel == 2'd0) |=> active); // R12
    AST_ACTIVE_UART_ON: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> uart_en); // R12
endmodule

bind uart_psave_ctrl psave_ctrl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_sel   (mode_sel),
    .flow_en    (flow_en),
    .rts_on     (rts_on),
    .tx_pend    (tx_pend),
    .usb_active (usb_active),
    .uart_en    (uart_en),
    .cts_n      (cts_n),
    .active     (active),
    .drop_first (drop_first)
);

// File: tb/tb_uart_psave_ctrl.sv
module tb_uart_psave_ctrl;
    localparam int T    = 6;
    localparam int IWIN = 4;
    localparam int PWIN = 3;
    localparam int WK   = 5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick;
    logic [1:0] mode_sel;
    logic       flow_en, rts_on, rxd, char_rx, tx_pend, usb_active;
    logic       uart_en, cts_n, active, drop_first;

    int vectors = 0;
    int fails   = 0;
    bit done    = 1'b0;

    uart_psave_ctrl #(
        .TIMEOUT_TICKS (T),
        .IDLE_WIN_TICKS(IWIN),
        .PEEK_TICKS    (PWIN),
        .WAKE_TICKS    (WK),
        .SYNC_STAGES   (2)
    ) dut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .mode_sel(mode_sel),
        .flow_en(flow_en), .rts_on(rts_on), .rxd(rxd), .char_rx(char_rx),
        .tx_pend(tx_pend), .usb_active(usb_active), .uart_en(uart_en),
        .cts_n(cts_n), .active(active), .drop_first(drop_first)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(posedge clk);
        #2;
    endtask

    task automatic cycn(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse_char();
        char_rx = 1'b1; cyc(); char_rx = 1'b0;
    endtask

    task automatic usb_restore();
        usb_active = 1'b1; cyc(); usb_active = 1'b0;
        chk("R11 usb wake", int'(active), 1);
    endtask

    // From a freshly loaded inactivity counter: T edges awake, then asleep
    task automatic go_idle(input string tag);
        cycn(T);
        chk(tag, int'(active), 1);
        cyc();
        chk(tag, int'(active), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; tick = 1'b1; mode_sel = 2'd1; flow_en = 1'b1;
        rts_on = 1'b0; rxd = 1'b0; char_rx = 1'b0; tx_pend = 1'b0; usb_active = 1'b0;
        cycn(3);
        chk("R1 active", int'(active), 1);
        chk("R1 uart_en", int'(uart_en), 1);
        chk("R1 cts_n", int'(cts_n), 0);
        chk("R1 drop", int'(drop_first), 0);
        rst_n = 1'b1;
        go_idle("R1 timer loaded at reset");
        usb_restore();

        // R2/R3 sweep of restart spacing
        for (int k = 0; k <= T; k++) begin
            pulse_char();
            cycn(k);
            pulse_char();
            cycn(T);
            chk("R3 restart holds", int'(active), 1);
            cyc();
            chk("R2 timeout", int'(active), 0);
            chk("R4 cts high asleep", int'(cts_n), 1);
            chk("R2 uart off", int'(uart_en), 0);
            tx_pend = 1'b1; #1;
            chk("R9 tx enables", int'(uart_en), 1);
            tx_pend = 1'b0; #1;
            chk("R9 tx release", int'(uart_en), 0);
            usb_restore();
        end

        // R2 tick gating
        tick = 1'b0;
        cycn(3 * T);
        chk("R2 no tick no timeout", int'(active), 1);
        tick = 1'b1;
        go_idle("R2 tick resumes");

        // R5 cyclic peek
        cycn(IWIN);
        chk("R5 still idle", int'(uart_en), 0);
        chk("R5 cts idle", int'(cts_n), 1);
        cyc();
        chk("R5 peek uart", int'(uart_en), 1);
        chk("R5 peek cts", int'(cts_n), 0);
        chk("R5 peek not active", int'(active), 0);
        cycn(PWIN);
        chk("R5 peek length", int'(uart_en), 1);
        cyc();
        chk("R5 back to idle", int'(uart_en), 0);
        chk("R5 back cts", int'(cts_n), 1);
        cycn(IWIN + 1);
        chk("R5 second peek", int'(uart_en), 1);
        pulse_char();
        chk("R5 char in peek", int'(active), 1);

        // R10 receive-edge wake at each offset in the sleep window
        for (int off = 0; off <= IWIN - 2; off++) begin
            go_idle("R10 setup");
            cycn(off);
            rxd = 1'b1;
            cycn(3);
            chk("R10 drop set", int'(drop_first), 1);
            chk("R10 waking", int'(active), 0);
            chk("R4 cts in wake", int'(cts_n), 1);
            pulse_char();
            cycn(WK - 1);
            chk("R10 latency holds", int'(active), 0);
            chk("R10 drop held", int'(drop_first), 1);
            cyc();
            chk("R10 active after wake", int'(active), 1);
            chk("R10 drop cleared", int'(drop_first), 0);
            rxd = 1'b0;
        end

        // R13 edge while active
        cycn(3);
        usb_restore();
        rxd = 1'b1;
        cycn(3);
        chk("R13 drop stays", int'(drop_first), 0);
        chk("R13 stays active", int'(active), 1);
        rxd = 1'b0;
        cycn(3);

        // R11 usb hold and usb during wake
        usb_active = 1'b1;
        cycn(3 * T);
        chk("R11 usb hold", int'(active), 1);
        usb_active = 1'b0;
        go_idle("R11 release");
        rxd = 1'b1;
        cycn(3);
        chk("R11 in wake", int'(drop_first), 1);
        usb_active = 1'b1; cyc(); usb_active = 1'b0;
        chk("R11 usb ends wake", int'(active), 1);
        chk("R11 drop cleared", int'(drop_first), 0);
        rxd = 1'b0;

        // R12 mode off
        go_idle("R12 setup");
        mode_sel = 2'd0;
        cyc();
        chk("R12 off wakes", int'(active), 1);
        cycn(3 * T);
        chk("R12 off stays", int'(active), 1);
        chk("R12 uart on", int'(uart_en), 1);

        // R8 illegal and reserved
        mode_sel = 2'd2; flow_en = 1'b1;
        cycn(3 * T);
        chk("R8 rts+flow no sleep", int'(active), 1);
        chk("R8 cts low", int'(cts_n), 0);
        mode_sel = 2'd3;
        cycn(3 * T);
        chk("R8 reserved no sleep", int'(active), 1);

        // R6/R7 RTS mode
        mode_sel = 2'd2; flow_en = 1'b0; rts_on = 1'b1;
        cycn(3 * T);
        chk("R6 rts holds", int'(active), 1);
        rts_on = 1'b0;
        go_idle("R6 rts off timeout");
        chk("R6 cts low", int'(cts_n), 0);
        chk("R6 uart off", int'(uart_en), 0);
        cycn(IWIN + PWIN + 3);
        chk("R6 no peek", int'(uart_en), 0);
        chk("R6 still idle", int'(active), 0);
        rts_on = 1'b1;
        cyc();
        chk("R7 wake no drop", int'(drop_first), 0);
        chk("R7 waking", int'(active), 0);
        cycn(WK);
        chk("R7 latency", int'(active), 0);
        cyc();
        chk("R7 active", int'(active), 1);
        chk("R7 uart on", int'(uart_en), 1);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule